// File: doc/BRIEF.md
# HDLC Dual-Width Frame Check Sequence Checker

This block sits behind an HDLC receive deframer that has already stripped the flags and removed stuffed zeros. It sees one byte per clock. A start strobe marks the first in-frame byte and an end strobe marks the last one. The block runs a cyclic redundancy check over every byte of the frame: address, control, information and the received check field. When the last byte has been folded in, it decides whether the frame arrived intact.

The check runs in one of two widths, a 16-bit CCITT code or a 32-bit code. A mode input picks the width, and the block captures it once per frame at the first byte. The register starts each frame from all ones. A frame is judged good when the remainder left after the check field equals the fixed residue of the selected width. The verdict is a single-cycle pulse on either `crc_ok` or `crc_err`, one clock after the end strobe. An abort input drops the frame in progress without giving a verdict.

Top module: `hdlc_fcs_check`

## Requirements
- R1: With `mode_sel`=0 (16-bit), the register is preset to 0xFFFF on the first byte of every frame. Bytes are folded in LSB first with the reflected polynomial 0x8408. A frame whose last two bytes are the ones' complement of the payload remainder, low byte first, gives `crc_ok`.
- R2: With `mode_sel`=1 (32-bit), the register is preset to 0xFFFFFFFF. Bytes are folded in LSB first with the reflected polynomial 0xEDB88320. A frame ending in the complemented 4-byte remainder, low byte first, gives `crc_ok`.
- R3: In 16-bit mode the frame is good only if the remainder after the last byte equals 0xF0B8. Otherwise `crc_err` pulses.
- R4: In 32-bit mode the frame is good only if the remainder after the last byte equals 0xDEBB20E3. Otherwise `crc_err` pulses.
- R5: Every in-frame byte counts, including the first (address) byte and the check-field bytes. Corrupting any one of them gives `crc_err`.
- R6: A byte is taken only on a cycle with `data_valid` high. Idle cycles inside a frame do not change the result.
- R7: `mode_sel` is captured on the first byte (`sof` with `data_valid`). Changes to it later in the frame have no effect.
- R8: Exactly one of `crc_ok` and `crc_err` pulses, for one cycle, exactly one cycle after the byte carrying `eof`. They are never high together.
- R9: `abort` ends the current frame at once and suppresses its verdict, even when it coincides with `eof`. The next frame is checked normally.
- R10: A new frame may start on the cycle right after the previous end byte, or in the same cycle as its own end byte (a one-byte frame). Each frame starts from a fresh preset.
- R11: Bytes and `eof` seen outside a frame are ignored and produce no verdict.
- R12: During and right after reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = 16-bit check, 1 = 32-bit check; captured at frame start |
| sof | input | 1 | First in-frame byte marker |
| eof | input | 1 | Last in-frame byte marker |
| data_valid | input | 1 | `data_in` carries a byte this cycle |
| data_in | input | 8 | Received byte |
| abort | input | 1 | Discard the current frame |
| crc_ok | output | 1 | One-cycle pulse: frame is error free |
| crc_err | output | 1 | One-cycle pulse: frame failed the check |

## Verification
The hardest cases to reach are the collisions at frame edges. These are an abort landing on the end byte, a new start strobe on the cycle right after an end byte, a one-byte frame whose start and end coincide, and a width change part-way through a frame. The driver places each of these on an exact cycle. It builds every good frame by computing the complemented remainder itself and appending it low byte first, and builds bad frames by flipping one bit in a chosen position. The scoreboard then expects a verdict on one exact cycle, and a silent output everywhere else.

// File: rtl/hdlc_fcs_pkg.sv
package hdlc_fcs_pkg;

    localparam int BYTE_W  = 8;
    localparam int CRC_W   = 32;
    localparam int NARROW_W = 16;

    localparam logic [NARROW_W-1:0] POLY_NARROW = 16'h8408;
    localparam logic [CRC_W-1:0]    POLY_WIDE   = 32'hEDB88320;
    localparam logic [CRC_W-1:0]    PRESET_NARROW = 32'h0000FFFF;
    localparam logic [CRC_W-1:0]    PRESET_WIDE   = 32'hFFFFFFFF;
    localparam logic [CRC_W-1:0]    RESID_NARROW  = 32'h0000F0B8;
    localparam logic [CRC_W-1:0]    RESID_WIDE    = 32'hDEBB20E3;

    typedef enum logic {
        FCS_NARROW = 1'b0,
        FCS_WIDE   = 1'b1
    } fcs_mode_e;

    typedef struct packed {
        logic            active;
        fcs_mode_e       mode;
        logic [CRC_W-1:0] crc;
    } fcs_state_t;

    typedef struct packed {
        logic ok;
        logic err;
    } fcs_verdict_t;

    function automatic logic [CRC_W-1:0] preset_of(fcs_mode_e m);
        return (m == FCS_WIDE) ? PRESET_WIDE : PRESET_NARROW;
    endfunction

    function automatic logic [CRC_W-1:0] residue_of(fcs_mode_e m);
        return (m == FCS_WIDE) ? RESID_WIDE : RESID_NARROW;
    endfunction

endpackage

// File: rtl/fcs_byte_update.sv
module fcs_byte_update #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   POLY = '0
) (
    input  logic [W-1:0] crc_in,
    input  logic [7:0]   byte_in,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] work;

    always_comb begin
        work = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (work[0] ^ byte_in[i])
                work = (work >> 1) ^ POLY;
            else
                work = work >> 1;
        end
        crc_out = work;
    end
endmodule

// File: rtl/fcs_frame_ctrl.sv
module fcs_frame_ctrl
    import hdlc_fcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_sel,
    input  logic                sof,
    input  logic                eof,
    input  logic                data_valid,
    input  logic                abort,
    input  logic [NARROW_W-1:0] upd_narrow,
    input  logic [CRC_W-1:0]    upd_wide,
    output logic [CRC_W-1:0]    base_crc,
    output logic                fire,
    output logic                good,
    output logic                frame_active,
    output fcs_mode_e           frame_mode
);
    fcs_state_t        st_q;
    logic              start;
    logic              accept;
    fcs_mode_e         mode_eff;
    logic [CRC_W-1:0]  crc_nxt;

    always_comb begin
        start    = data_valid && sof && !abort;
        accept   = data_valid && !abort && (start || st_q.active);
        mode_eff = start ? fcs_mode_e'(mode_sel) : st_q.mode;
        base_crc = start ? preset_of(mode_eff) : st_q.crc;
        crc_nxt  = (mode_eff == FCS_WIDE) ? upd_wide
                                          : {{(CRC_W-NARROW_W){1'b0}}, upd_narrow};
        fire     = accept && eof;
        good     = (crc_nxt == residue_of(mode_eff));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= 1'b0;
            st_q.mode   <= FCS_NARROW;
            st_q.crc    <= '0;
        end else if (abort) begin
            st_q.active <= 1'b0;
        end else if (accept) begin
            st_q.crc    <= crc_nxt;
            st_q.active <= !eof;
            if (start)
                st_q.mode <= mode_eff;
        end
    end

    assign frame_active = st_q.active;
    assign frame_mode   = st_q.mode;
endmodule

// File: rtl/fcs_verdict.sv
module fcs_verdict
    import hdlc_fcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic good,
    output logic crc_ok,
    output logic crc_err
);
    fcs_verdict_t v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
        end else begin
            v_q.ok  <= fire && good;
            v_q.err <= fire && !good;
        end
    end

    assign crc_ok  = v_q.ok;
    assign crc_err = v_q.err;
endmodule

// File: rtl/hdlc_fcs_check.sv
module hdlc_fcs_check
    import hdlc_fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_sel,
    input  logic       sof,
    input  logic       eof,
    input  logic       data_valid,
    input  logic [7:0] data_in,
    input  logic       abort,
    output logic       crc_ok,
    output logic       crc_err
);
    logic [CRC_W-1:0]    base_crc;
    logic [NARROW_W-1:0] upd_narrow;
    logic [CRC_W-1:0]    upd_wide;
    logic                fire;
    logic                good;
    logic                frame_active;
    fcs_mode_e           frame_mode;

    fcs_byte_update #(.W(NARROW_W), .POLY(POLY_NARROW)) u_upd_narrow (
        .crc_in  (base_crc[NARROW_W-1:0]),
        .byte_in (data_in),
        .crc_out (upd_narrow)
    );

    fcs_byte_update #(.W(CRC_W), .POLY(POLY_WIDE)) u_upd_wide (
        .crc_in  (base_crc),
        .byte_in (data_in),
        .crc_out (upd_wide)
    );

    fcs_frame_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .mode_sel     (mode_sel),
        .sof          (sof),
        .eof          (eof),
        .data_valid   (data_valid),
        .abort        (abort),
        .upd_narrow   (upd_narrow),
        .upd_wide     (upd_wide),
        .base_crc     (base_crc),
        .fire         (fire),
        .good         (good),
        .frame_active (frame_active),
        .frame_mode   (frame_mode)
    );

    fcs_verdict u_verdict (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .good    (good),
        .crc_ok  (crc_ok),
        .crc_err (crc_err)
    );
endmodule

// File: rtl/hdlc_fcs_sva.sv
module hdlc_fcs_sva
    import hdlc_fcs_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sof,
    input logic      eof,
    input logic      data_valid,
    input logic      abort,
    input logic      crc_ok,
    input logic      crc_err,
    input logic      frame_active,
    input fcs_mode_e frame_mode
);
    // R8: the two verdicts never coincide
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(crc_ok && crc_err));

    // R8 / R11: a verdict only follows an accepted end byte
    a_r8_after_eof: assert property (@(posedge clk) disable iff (rst)
        (crc_ok || crc_err) |-> $past(eof && data_valid && !abort));

    // R9: an abort cycle is never followed by a verdict
    a_r9_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        abort |=> !(crc_ok || crc_err));

    // R9: abort leaves no frame open
    a_r9_abort_closes: assert property (@(posedge clk) disable iff (rst)
        abort |=> !frame_active);

    // R7: captured width holds until a new frame starts
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (frame_active && !(sof && data_valid)) |=> $stable(frame_mode));

    // R12: outputs low after a reset cycle
    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> (!crc_ok && !crc_err));
endmodule

bind hdlc_fcs_check hdlc_fcs_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .sof          (sof),
    .eof          (eof),
    .data_valid   (data_valid),
    .abort        (abort),
    .crc_ok       (crc_ok),
    .crc_err      (crc_err),
    .frame_active (frame_active),
    .frame_mode   (frame_mode)
);

// File: tb/tb_hdlc_fcs_check.sv
module tb_hdlc_fcs_check;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic       sof = 1'b0;
    logic       eof = 1'b0;
    logic       data_valid = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       abort = 1'b0;
    logic       crc_ok;
    logic       crc_err;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    ok;
        string req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    hdlc_fcs_check dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .sof(sof), .eof(eof),
        .data_valid(data_valid), .data_in(data_in), .abort(abort),
        .crc_ok(crc_ok), .crc_err(crc_err)
    );

    function automatic logic [31:0] ref_crc(bit wide, logic [7:0] b[$]);
        logic [31:0] r = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
        logic [31:0] p = wide ? 32'hEDB88320 : 32'h00008408;
        foreach (b[k])
            for (int i = 0; i < 8; i++)
                r = ((r[0] ^ b[k][i]) != 1'b0) ? ((r >> 1) ^ p) : (r >> 1);
        return r;
    endfunction

    function automatic bit ref_good(bit wide, logic [7:0] b[$]);
        logic [31:0] r = ref_crc(wide, b);
        return wide ? (r == 32'hDEBB20E3) : (r[15:0] == 16'hF0B8);
    endfunction

    task automatic make_frame(bit wide, int n, output logic [7:0] f[$]);
        logic [31:0] c;
        f = {};
        for (int i = 0; i < n; i++) f.push_back(8'($urandom));
        c = ~ref_crc(wide, f);
        for (int i = 0; i < (wide ? 4 : 2); i++) f.push_back(c[8*i +: 8]);
    endtask

    // Drive a frame; gap inserts idle cycles; flip_mode toggles mode_sel after byte 0.
    task automatic send(bit wide, logic [7:0] f[$], bit gap, bit flip_mode,
                        bit abort_at_end, string req);
        foreach (f[k]) begin
            if (gap && k != 0) begin
                data_valid = 1'b0; sof = 1'b0; eof = 1'b0;
                @(negedge clk);
            end
            data_valid = 1'b1;
            data_in    = f[k];
            sof        = (k == 0);
            eof        = (k == f.size() - 1);
            mode_sel   = (flip_mode && k != 0) ? !wide : wide;
            abort      = abort_at_end && eof;
            if (eof && !abort) begin
                exp_t e;
                e.at = cyc + 1; e.ok = ref_good(wide, f); e.req = req;
                sb.push_back(e);
            end
            @(negedge clk);
        end
        data_valid = 1'b0; sof = 1'b0; eof = 1'b0; abort = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sb.size() != 0 && sb[0].at == cyc) begin
                tests++;
                if (crc_ok !== sb[0].ok || crc_err !== !sb[0].ok) begin
                    fails++;
                    $display("FAIL %s: ok/err=%b%b expected %b%b at cycle %0d",
                             sb[0].req, crc_ok, crc_err, sb[0].ok, !sb[0].ok, cyc);
                end
                void'(sb.pop_front());
            end else if (crc_ok || crc_err) begin
                tests++; fails++;
                $display("FAIL R8/R9/R11: unexpected verdict ok/err=%b%b expected 00 at cycle %0d",
                         crc_ok, crc_err, cyc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] f[$];
        logic [7:0] g[$];
        repeat (3) @(negedge clk);
        tests++;   // R12
        if (crc_ok !== 1'b0 || crc_err !== 1'b0) begin
            fails++;
            $display("FAIL R12: ok/err=%b%b expected 00 in reset", crc_ok, crc_err);
        end
        rst = 1'b0;
        @(negedge clk);

        // R1: good 16-bit frames of several lengths
        make_frame(0, 4, f);  send(0, f, 0, 0, 0, "R1"); idle(2);
        make_frame(0, 17, f); send(0, f, 0, 0, 0, "R1"); idle(2);
        // R2: good 32-bit frames
        make_frame(1, 5, f);  send(1, f, 0, 0, 0, "R2"); idle(2);
        make_frame(1, 30, f); send(1, f, 0, 0, 0, "R2"); idle(2);
        // R3: corrupted data byte, 16-bit
        make_frame(0, 8, f); f[4] ^= 8'h10; send(0, f, 0, 0, 0, "R3"); idle(2);
        // R4: corrupted data byte, 32-bit
        make_frame(1, 8, f); f[3] ^= 8'h01; send(1, f, 0, 0, 0, "R4"); idle(2);
        // R5: address byte and check-field bytes count
        make_frame(0, 6, f); f[0] ^= 8'h80; send(0, f, 0, 0, 0, "R5"); idle(2);
        make_frame(1, 6, f); f[f.size()-1] ^= 8'h40; send(1, f, 0, 0, 0, "R5"); idle(2);
        make_frame(0, 6, f); f[f.size()-2] ^= 8'h02; send(0, f, 0, 0, 0, "R5"); idle(2);
        // R6: idle cycles within a frame
        make_frame(1, 10, f); send(1, f, 1, 0, 0, "R6"); idle(2);
        make_frame(0, 10, f); send(0, f, 1, 0, 0, "R6"); idle(2);
        // R7: mode flips after first byte, width stays as captured
        make_frame(0, 9, f); send(0, f, 0, 1, 0, "R7"); idle(2);
        make_frame(1, 9, f); send(1, f, 0, 1, 0, "R7"); idle(2);
        // R9: abort mid-frame, then a good frame
        make_frame(1, 12, f);
        g = f[0:5];
        send(1, g, 0, 0, 1, "R9");
        idle(3);
        make_frame(1, 7, f); send(1, f, 0, 0, 0, "R9"); idle(2);
        // R9: abort on end byte of a good frame
        make_frame(0, 7, f); send(0, f, 0, 0, 1, "R9"); idle(3);
        // R10: back-to-back frames, mixed widths
        make_frame(0, 5, f); send(0, f, 0, 0, 0, "R10");
        make_frame(1, 5, f); send(1, f, 0, 0, 0, "R10");
        make_frame(0, 3, f); f[1] ^= 8'h08; send(0, f, 0, 0, 0, "R10");
        make_frame(0, 3, f); send(0, f, 0, 0, 0, "R10");
        // R10: one-byte frames (start and end together)
        g = {8'hA5}; send(1, g, 0, 0, 0, "R10");
        g = {8'h3C}; send(0, g, 0, 0, 0, "R10");
        idle(2);
        // R11: stray bytes and eof outside a frame
        data_valid = 1'b1; data_in = 8'h7E; eof = 1'b1; @(negedge clk);
        eof = 1'b0; @(negedge clk);
        data_valid = 1'b0; idle(3);
        make_frame(0, 4, f); send(0, f, 0, 0, 0, "R11"); idle(3);

        tests++;   // R8: every expected verdict was observed
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d verdicts missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule